// File: doc/BRIEF.md
# 56-bit Signed Multiply-Accumulate Unit

This block keeps a 56-bit signed accumulator for fixed-point signal processing. On each cycle with `op_valid` high it runs one operation selected by `op_code`: a multiply that replaces the accumulator, a multiply that adds to it, a write of the upper or lower 32 bits, or one of two round-and-saturate steps. Multiplies take a 32-bit or upper/lower-16-bit field of `src_a` and multiply it by a signed halfword of `src_b`. Every new value is kept to 56 bits and treated as sign-extended.

Reads are combinational. A read code on `op_code` places a 32-bit window of the 64-bit sign-extension of the accumulator on `rd_data`, and the accumulator does not change. Operand fetch and register writeback belong to the surrounding pipeline. The full accumulator is visible on `acc_out`.

Top module: `dsp_mac56`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the accumulator to zero. It has priority over any operation.
- R2: Codes 0 and 1 replace the accumulator with a signed 48-bit product, sign-extended. Code 0 multiplies `src_a` with its low 16 bits cleared by the signed `src_b[31:16]`. Code 1 multiplies `src_a` shifted left by 16 (a 32-bit value) by the signed `src_b[15:0]`.
- R3: Codes 2 and 3 replace the accumulator with the full signed `src_a` times the signed `src_b[31:16]` (code 2) or the signed `src_b[15:0]` (code 3).
- R4: Codes 4 to 7 form the same products as codes 0 to 3 and add them to the accumulator. The sum wraps modulo 2^56.
- R5: Code 8 drives bits 63:32 of the sign-extended accumulator on `rd_data`. Code 9 drives bits 47:16 and code 10 drives bits 31:0. Any other code drives zero. A read leaves the accumulator unchanged.
- R6: Code 11 keeps accumulator bits 31:0 and loads `src_a[23:0]` into bits 55:32.
- R7: Code 12 loads `src_a` into bits 31:0. When `src_a[31]` is 1 it also sets bits 55:32; otherwise it keeps them.
- R8: Code 13 rounds to a word. The accumulator is read as an unsigned value T. If T is in [0x3FFFFFFF8000, 0x7FFFFFFFFFFFFF], T becomes 0x3FFFFFFF8000. Otherwise, if T is in [0x80000000000000, 0xFFC00000000000], T becomes 0xFFC00000000000. Otherwise T becomes (T+0x4000) AND 0xFFFFFFFFFF8000. The result is T shifted left by 1 and truncated to 56 bits.
- R9: Code 14 is the same as R8 with these changes: the first range starts at 0x3FFF80000000, and the positive saturation value is 0x3FFF80000000. The normal case adds 0x40000000 and masks with 0xFFFFFF80000000.
- R10: With `op_valid` low, or with code 15, the accumulator does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Runs `op_code` at this edge |
| op_code | input | 4 | Operation select |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand (halfword source) |
| rd_data | output | 32 | Selected accumulator window on read codes |
| acc_out | output | 56 | Accumulator value |

## Verification
The whole accumulator is on `acc_out`, so a wrong result from a multiply, a write or a round shows one cycle after the edge that ran the operation. A bad multiply-accumulate can be hidden by a later replace or write, so each result is compared right after the cycle that produced it. Saturation-range errors appear only near the range bounds, so those bounds and their immediate neighbours are driven on purpose. Read windows are checked within the same cycle, before the edge.

// File: rtl/dsp_mac56.sv
module dsp_mac56 #(
  parameter int ACC_W = 56,
  parameter int DAT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic [DAT_W-1:0] src_a,
  input  logic [DAT_W-1:0] src_b,
  output logic [DAT_W-1:0] rd_data,
  output logic [ACC_W-1:0] acc_out
);
  localparam int HW    = DAT_W / 2;
  localparam int PW    = DAT_W + HW;
  localparam int XW    = 2 * DAT_W;
  localparam int TOP_W = ACC_W - DAT_W;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [XW-1:0]    acc_x;
  logic [DAT_W-1:0] mul_l;
  logic [HW-1:0]    mul_r;
  logic signed [PW-1:0] prod;
  logic [ACC_W-1:0] prod_x;

  assign acc_x  = {{(XW-ACC_W){acc_q[ACC_W-1]}}, acc_q};
  assign mul_l  = op_code[1] ? src_a
                : op_code[0] ? {src_a[HW-1:0], {HW{1'b0}}}
                             : {src_a[DAT_W-1:HW], {HW{1'b0}}};
  assign mul_r  = op_code[0] ? src_b[HW-1:0] : src_b[DAT_W-1:HW];
  assign prod   = $signed(mul_l) * $signed(mul_r);
  assign prod_x = {{(ACC_W-PW){prod[PW-1]}}, prod};

  function automatic logic [ACC_W-1:0] round_sat(input logic [ACC_W-1:0] a, input logic hi);
    logic [ACC_W-1:0] t, lo_b, addc, msk;
    lo_b = hi ? 56'h003FFF80000000 : 56'h003FFFFFFF8000;
    addc = hi ? 56'h00000040000000 : 56'h00000000004000;
    msk  = hi ? 56'hFFFFFF80000000 : 56'hFFFFFFFFFF8000;
    if (a >= lo_b && a <= 56'h7FFFFFFFFFFFFF)
      t = lo_b;
    else if (a >= 56'h80000000000000 && a <= 56'hFFC00000000000)
      t = 56'hFFC00000000000;
    else
      t = (a + addc) & msk;
    return {t[ACC_W-2:0], 1'b0};
  endfunction

  always_comb begin
    acc_d = acc_q;
    if (op_valid) begin
      case (op_code)
        4'h0, 4'h1, 4'h2, 4'h3: acc_d = prod_x;
        4'h4, 4'h5, 4'h6, 4'h7: acc_d = acc_q + prod_x;
        4'hB: acc_d = {src_a[TOP_W-1:0], acc_q[DAT_W-1:0]};
        4'hC: acc_d = {acc_q[ACC_W-1:DAT_W] | {TOP_W{src_a[DAT_W-1]}}, src_a};
        4'hD: acc_d = round_sat(acc_q, 1'b0);
        4'hE: acc_d = round_sat(acc_q, 1'b1);
        default: acc_d = acc_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end

  always_comb begin
    case (op_code)
      4'h8:    rd_data = acc_x[XW-1:DAT_W];
      4'h9:    rd_data = acc_x[DAT_W+HW-1:HW];
      4'hA:    rd_data = acc_x[DAT_W-1:0];
      default: rd_data = '0;
    endcase
  end

  assign acc_out = acc_q;
endmodule

// File: rtl/dsp_mac56_chk.sv
module dsp_mac56_chk (
  input logic        clk,
  input logic        rst,
  input logic        op_valid,
  input logic [3:0]  op_code,
  input logic [31:0] src_a,
  input logic [55:0] acc_out
);
  assert_half_sext_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 4'h0 || op_code == 4'h1)) |=> (acc_out[55:47] == {9{acc_out[47]}}));

  assert_read_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 4'h8 || op_code == 4'h9 || op_code == 4'hA)) |=> $stable(acc_out));

  assert_wr_high_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'hB) |=> (acc_out == {$past(src_a[23:0]), $past(acc_out[31:0])}));

  assert_wr_low_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'hC) |=> (acc_out[31:0] == $past(src_a)));

  assert_rnd_word_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'hD) |=> (acc_out[15:0] == 16'h0));

  assert_rnd_high_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'hE) |=> (acc_out[31:0] == 32'h0));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_code == 4'hF) |=> $stable(acc_out));
endmodule

bind dsp_mac56 dsp_mac56_chk u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .src_a(src_a), .acc_out(acc_out)
);

// File: tb/dsp_mac56_tb.sv
module dsp_mac56_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'hF;
  logic [31:0] src_a = '0, src_b = '0;
  logic [31:0] rd_data;
  logic [55:0] acc_out;

  int checks = 0;
  int errors = 0;
  logic [55:0] model = '0;
  bit done = 0;

  always #4 clk = ~clk;

  dsp_mac56 u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .rd_data(rd_data), .acc_out(acc_out)
  );

  function automatic string tag(input logic [3:0] c);
    case (c)
      4'h0, 4'h1: return "R2";
      4'h2, 4'h3: return "R3";
      4'h4, 4'h5, 4'h6, 4'h7: return "R4";
      4'h8, 4'h9, 4'hA: return "R5";
      4'hB: return "R6";
      4'hC: return "R7";
      4'hD: return "R8";
      4'hE: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [55:0] rnd_ref(input logic [55:0] acc, input bit hi);
    logic [63:0] t, lo_b, addc, msk;
    t    = {8'h0, acc};
    lo_b = hi ? 64'h00003FFF80000000 : 64'h00003FFFFFFF8000;
    addc = hi ? 64'h40000000 : 64'h4000;
    msk  = hi ? 64'hFFFFFFFF80000000 : 64'h00FFFFFFFFFF8000;
    if (t >= lo_b && t <= 64'h007FFFFFFFFFFFFF) t = lo_b;
    else if (t >= 64'h0080000000000000 && t <= 64'h00FFC00000000000) t = 64'h00FFC00000000000;
    else t = ({{8{acc[55]}}, acc} + addc) & msk;
    t = t << 1;
    return t[55:0];
  endfunction

  function automatic logic [55:0] next_ref(input logic [3:0] c, input logic [31:0] a,
                                           input logic [31:0] b, input logic [55:0] acc);
    longint x, y, p;
    logic [31:0] sh;
    sh = a << 16;
    case (c[1:0])
      2'd0: begin x = longint'($signed(a & 32'hFFFF0000)); y = longint'($signed(b[31:16])); end
      2'd1: begin x = longint'($signed(sh));               y = longint'($signed(b[15:0]));  end
      2'd2: begin x = longint'($signed(a));                y = longint'($signed(b[31:16])); end
      default: begin x = longint'($signed(a));             y = longint'($signed(b[15:0]));  end
    endcase
    p = x * y;
    case (c)
      4'h0, 4'h1: return {{8{p[47]}}, p[47:0]};
      4'h2, 4'h3: return p[55:0];
      4'h4, 4'h5, 4'h6, 4'h7: return acc + p[55:0];
      4'hB: return {a[23:0], acc[31:0]};
      4'hC: begin
        logic [63:0] w;
        w = ({{8{acc[55]}}, acc} & 64'hFFFFFFFF00000000) | {{32{a[31]}}, a};
        return w[55:0];
      end
      4'hD: return rnd_ref(acc, 1'b0);
      4'hE: return rnd_ref(acc, 1'b1);
      default: return acc;
    endcase
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic v, input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ax;
    logic [31:0] rexp;
    logic [55:0] nx;
    op_valid = v; op_code = c; src_a = a; src_b = b;
    #1;
    ax = {{8{model[55]}}, model};
    case (c)
      4'h8: rexp = ax[63:32];
      4'h9: rexp = ax[47:16];
      4'hA: rexp = ax[31:0];
      default: rexp = '0;
    endcase
    check({32'h0, rd_data}, {32'h0, rexp}, "R5 read window");
    nx = v ? next_ref(c, a, b, model) : model;
    @(posedge clk); #2;
    check({8'h0, acc_out}, {8'h0, nx}, v ? tag(c) : "R10 idle");
    model = nx;
  endtask

  task automatic load(input logic [55:0] v);
    run_op(1'b1, 4'hB, {8'h0, v[55:32]}, 32'h0);
    run_op(1'b1, 4'hC, v[31:0], 32'h0);
    if (v[31]) run_op(1'b1, 4'hB, {8'h0, v[55:32]}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check({8'h0, acc_out}, 64'h0, "R1 reset");
    rst = 1'b0;
    // R2, R3 directed
    run_op(1'b1, 4'h0, 32'h80001234, 32'h8000FFFF);
    run_op(1'b1, 4'h1, 32'h0000FFFF, 32'h00017FFF);
    run_op(1'b1, 4'h2, 32'h80000000, 32'h80000000);
    run_op(1'b1, 4'h3, 32'h7FFFFFFF, 32'h0000FFFF);
    // R4 wrap
    load(56'h7FFFFFFFFFFFF0);
    run_op(1'b1, 4'h7, 32'h00000100, 32'h00000001);
    run_op(1'b1, 4'h4, 32'hFFFF0000, 32'h7FFF0000);
    // R5 reads
    load(56'h89ABCDEF012345);
    run_op(1'b1, 4'h8, 32'h0, 32'h0);
    run_op(1'b1, 4'h9, 32'h0, 32'h0);
    run_op(1'b1, 4'hA, 32'h0, 32'h0);
    // R7 negative operand
    load(56'h12345600000000);
    run_op(1'b1, 4'hC, 32'h80000001, 32'h0);
    // R8 corners
    load(56'h003FFFFFFF7FFF); run_op(1'b1, 4'hD, 0, 0);
    load(56'h003FFFFFFF8000); run_op(1'b1, 4'hD, 0, 0);
    load(56'h7FFFFFFFFFFFFF); run_op(1'b1, 4'hD, 0, 0);
    load(56'h80000000000000); run_op(1'b1, 4'hD, 0, 0);
    load(56'hFFC00000000000); run_op(1'b1, 4'hD, 0, 0);
    load(56'hFFC00000000001); run_op(1'b1, 4'hD, 0, 0);
    load(56'h00123456789ABC); run_op(1'b1, 4'hD, 0, 0);
    // R9 corners
    load(56'h003FFF7FFFFFFF); run_op(1'b1, 4'hE, 0, 0);
    load(56'h003FFF80000000); run_op(1'b1, 4'hE, 0, 0);
    load(56'h90000000000000); run_op(1'b1, 4'hE, 0, 0);
    load(56'hFFFFFF12345678); run_op(1'b1, 4'hE, 0, 0);
    // R10
    run_op(1'b0, 4'h4, 32'h12345678, 32'h12345678);
    run_op(1'b1, 4'hF, 32'h12345678, 32'h12345678);
    // random
    void'($urandom(32'd2024));
    for (int i = 0; i < 600; i++) begin
      logic [3:0] c;
      c = 4'($urandom_range(0, 15));
      run_op(($urandom_range(0, 9) != 0), c, $urandom, $urandom);
    end
    // R1 mid-run reset
    load(56'h00ABCDEF123456);
    rst = 1'b1;
    op_valid = 1'b1; op_code = 4'h4; src_a = 32'h7FFFFFFF; src_b = 32'h7FFF7FFF;
    @(posedge clk); #2;
    check({8'h0, acc_out}, 64'h0, "R1 reset priority");
    rst = 1'b0; op_valid = 1'b0;
    model = '0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule